// File: doc/BRIEF.md
# Tick-Driven Synaptic Delay Spike Integrator

This block models one neuron fed by address-event spike packets. Each incoming packet carries a 30-bit source address. The low 10 bits select an entry in a small writable synapse table, and that entry supplies an axonal delay and a signed weight. The packet is then parked in a delay buffer with its age set to zero. Packets may arrive in any cycle. They have no phase relation to the slow biological tick.

Each tick pulse starts a fixed four-state sequence:
1. Every buffered entry ages by one.
2. Entries whose age has reached their delay leave the buffer, and their weights are summed.
3. The membrane value takes one forward-Euler leaky step with that sum added.
4. Any spike decided on the previous tick is emitted as an output packet.

When the new value reaches the threshold, the membrane is reset and a spike is requested. That spike leaves at the next tick, not at once. The output packet carries this neuron's own address: a 16-bit node field, then a 4-bit core field, then a 10-bit neuron field, from the most significant bit down.

Top module: `spk_delay_integrator`

## Requirements
- R1: A packet whose synapse delay is d (1 to 15) adds its weight to the membrane on exactly the d-th tick after it was accepted, and on no earlier tick.
- R2: A synapse delay of 0 behaves as a delay of 1: the weight is applied on the first tick after acceptance.
- R3: On every tick, including ticks with no matured input, the membrane value v becomes v - (v >>> LEAK_SHIFT) + S, where S is the sum of the matured weights. The result is clipped to the signed membrane range. The value is visible on `v_state`.
- R4: When the stepped value is at least THRESH, `v_state` becomes V_RESET and a spike is requested. `v_state` therefore never holds a value of THRESH or above.
- R5: A requested spike appears on the output only during the sequence of the following tick. Its `out_addr` is {NODE_ID[15:0], CORE_ID[3:0], NRN_ID[9:0]}, with bits 29:14 node, 13:10 core and 9:0 neuron. `out_valid` is high only while `busy` is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_addr` hold, and the tick sequence does not finish.
- R7: When all DEPTH buffer slots are occupied, `in_ready` is low. It rises again only after a tick has retired an entry. No packet is lost.
- R8: `in_ready` is low while `busy` or `tick` is high. A packet offered in the same cycle as a tick is therefore accepted only after that tick's ageing, with age zero.
- R9: A tick that arrives while a sequence runs is remembered and processed right after it. `busy` stays high across both sequences.
- R10: A write with `tbl_we` high stores the delay and weight for neuron index `tbl_addr`. Lookups use only `in_addr[9:0]`, and the node and core fields of the input have no effect.
- R11: Several entries that mature on the same tick are summed and applied together in a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input packet offered |
| in_ready | output | 1 | Input packet can be taken |
| in_addr | input | 30 | Source address of the incoming spike |
| tick | input | 1 | Single-cycle biological time pulse |
| busy | output | 1 | Tick sequence running or pending |
| tbl_we | input | 1 | Synapse table write strobe |
| tbl_addr | input | 10 | Synapse table index |
| tbl_delay | input | DLY_W | Delay value to store |
| tbl_weight | input | WW | Signed weight to store |
| out_valid | output | 1 | Output spike packet offered |
| out_ready | input | 1 | Output spike packet taken |
| out_addr | output | 30 | Address of the emitting neuron |
| v_state | output | VW | Signed membrane value |

## Verification
The bound checker watches several rules on every cycle:
- `in_ready` stays low under `busy` or `tick`.
- A late tick keeps `busy` high.
- A stalled output packet holds steady, its address is fixed, and it appears only inside a sequence.
- The membrane stays below threshold.

Other behaviour shows only in the bench's scenarios, which compare `v_state` and the spike count with an independent model after each tick. These scenarios cover:
- the exact tick on which a delayed weight lands;
- summing of simultaneous matures;
- the one-tick deferral of a spike;
- the full-buffer stall;
- ordering when a packet and a tick coincide.

// File: rtl/spk_pkg.sv
package spk_pkg;
   localparam int NODE_W = 16;
   localparam int CORE_W = 4;
   localparam int NRN_W  = 10;
   localparam int ADDR_W = NODE_W + CORE_W + NRN_W;

   typedef struct packed {
      logic [NODE_W-1:0] node;
      logic [CORE_W-1:0] core;
      logic [NRN_W-1:0]  nrn;
   } spk_addr_t;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_AGE    = 3'd1,
      SQ_RETIRE = 3'd2,
      SQ_INTEG  = 3'd3,
      SQ_EMIT   = 3'd4
   } seq_t;
endpackage

// File: rtl/spk_syn_table.sv
module spk_syn_table #(
   parameter int IDX_W = 10,
   parameter int DLY_W = 4,
   parameter int WW    = 8
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [IDX_W-1:0]     waddr,
   input  logic [DLY_W-1:0]     wdelay,
   input  logic signed [WW-1:0] wweight,
   input  logic [IDX_W-1:0]     raddr,
   output logic [DLY_W-1:0]     rdelay,
   output logic signed [WW-1:0] rweight
);
   localparam int ENTRIES = 1 << IDX_W;

   logic [DLY_W-1:0]     dly_mem [ENTRIES];
   logic signed [WW-1:0] wt_mem  [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) begin
         dly_mem[waddr] <= wdelay;
         wt_mem[waddr]  <= wweight;
      end
   end

   assign rdelay  = dly_mem[raddr];
   assign rweight = wt_mem[raddr];
endmodule

// File: rtl/spk_delay_buf.sv
module spk_delay_buf #(
   parameter int DEPTH = 8,
   parameter int DLY_W = 4,
   parameter int WW    = 8,
   parameter int SUM_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_en,
   input  logic [DLY_W-1:0]        ins_delay,
   input  logic signed [WW-1:0]    ins_weight,
   input  logic                    age_en,
   input  logic                    retire_en,
   output logic                    full,
   output logic signed [SUM_W-1:0] mat_sum
);
   logic [DEPTH-1:0]     vld_q;
   logic [DLY_W-1:0]     age_q [DEPTH];
   logic [DLY_W-1:0]     dly_q [DEPTH];
   logic signed [WW-1:0] wt_q  [DEPTH];
   logic [DEPTH-1:0]     slot_sel;
   logic [DEPTH-1:0]     mature;

   // first free slot, lowest index wins
   always_comb begin
      logic found;
      found    = 1'b0;
      slot_sel = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld_q[i] && !found) begin
            slot_sel[i] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   assign full = &vld_q;

   always_comb begin
      logic signed [SUM_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (mature[i]) acc = acc + SUM_W'(wt_q[i]);
      end
      mat_sum = acc;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign mature[g] = vld_q[g] && (age_q[g] >= dly_q[g]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            age_q[g] <= '0;
            dly_q[g] <= '0;
            wt_q[g]  <= '0;
         end else if (ins_en && slot_sel[g]) begin
            vld_q[g] <= 1'b1;
            age_q[g] <= '0;
            dly_q[g] <= ins_delay;
            wt_q[g]  <= ins_weight;
         end else if (age_en && vld_q[g] && (age_q[g] != '1)) begin
            age_q[g] <= age_q[g] + 1'b1;
         end else if (retire_en && mature[g]) begin
            vld_q[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spk_neuron_step.sv
module spk_neuron_step #(
   parameter int VW         = 16,
   parameter int SUM_W      = 12,
   parameter int LEAK_SHIFT = 3,
   parameter int THRESH     = 100,
   parameter int V_RESET    = 0
) (
   input  logic signed [VW-1:0]    v_in,
   input  logic signed [SUM_W-1:0] sum_in,
   output logic signed [VW-1:0]    v_out,
   output logic                    fire
);
   localparam int EW   = ((VW > SUM_W) ? VW : SUM_W) + 2;
   localparam int HI_I = (1 << (VW - 1)) - 1;
   localparam int LO_I = -(1 << (VW - 1));

   logic signed [EW-1:0] leak_e;
   logic signed [EW-1:0] raw;
   logic signed [VW-1:0] v_sat;

   if (LEAK_SHIFT == 0) begin : g_no_leak
      assign leak_e = '0;
   end else begin : g_leak
      assign leak_e = EW'(v_in >>> LEAK_SHIFT);
   end

   assign raw = EW'(v_in) - leak_e + EW'(sum_in);

   always_comb begin
      if (raw > EW'(HI_I))      v_sat = VW'(HI_I);
      else if (raw < EW'(LO_I)) v_sat = VW'(LO_I);
      else                      v_sat = VW'(raw);
   end

   assign fire  = (v_sat >= VW'(THRESH));
   assign v_out = fire ? VW'(V_RESET) : v_sat;
endmodule

// File: rtl/spk_delay_integrator.sv
module spk_delay_integrator
   import spk_pkg::*;
#(
   parameter int          DEPTH      = 8,
   parameter int          DLY_W      = 4,
   parameter int          WW         = 8,
   parameter int          VW         = 16,
   parameter int          LEAK_SHIFT = 3,
   parameter int          THRESH     = 100,
   parameter int          V_RESET    = 0,
   parameter logic [15:0] NODE_ID    = 16'h0A5C,
   parameter logic [3:0]  CORE_ID    = 4'h3,
   parameter logic [9:0]  NRN_ID     = 10'h12F
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [29:0]          in_addr,
   input  logic                 tick,
   output logic                 busy,
   input  logic                 tbl_we,
   input  logic [9:0]           tbl_addr,
   input  logic [DLY_W-1:0]     tbl_delay,
   input  logic signed [WW-1:0] tbl_weight,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [29:0]          out_addr,
   output logic signed [VW-1:0] v_state
);
   localparam int SUM_W = WW + $clog2(DEPTH) + 1;

   if (DEPTH < 2) begin : g_chk_depth
      $error("DEPTH must be at least 2");
   end
   if (DLY_W < 1) begin : g_chk_dly
      $error("DLY_W must be at least 1");
   end
   if (VW < 4 || VW > 31) begin : g_chk_vw
      $error("VW must lie in 4..31");
   end
   if (V_RESET >= THRESH) begin : g_chk_reset
      $error("V_RESET must be below THRESH");
   end
   if (THRESH > (1 << (VW - 1)) - 1) begin : g_chk_thresh
      $error("THRESH must fit the membrane width");
   end

   spk_addr_t src;
   logic      unused_fields;
   assign src           = in_addr;
   assign unused_fields = ^{src.node, src.core};

   seq_t                    state_q;
   logic                    pend_q;
   logic                    req_q;
   logic                    arm_q;
   logic signed [SUM_W-1:0] sum_q;
   logic signed [VW-1:0]    v_q;

   logic                    full;
   logic signed [SUM_W-1:0] mat_sum;
   logic [DLY_W-1:0]        lk_delay;
   logic signed [WW-1:0]    lk_weight;
   logic signed [VW-1:0]    v_next;
   logic                    fire;
   logic                    accept;

   assign busy     = (state_q != SQ_IDLE) || pend_q;
   assign in_ready = !full && (state_q == SQ_IDLE) && !pend_q && !tick;
   assign accept   = in_valid && in_ready;

   spk_syn_table #(.IDX_W(NRN_W), .DLY_W(DLY_W), .WW(WW)) u_table (
      .clk     (clk),
      .we      (tbl_we),
      .waddr   (tbl_addr),
      .wdelay  (tbl_delay),
      .wweight (tbl_weight),
      .raddr   (src.nrn),
      .rdelay  (lk_delay),
      .rweight (lk_weight)
   );

   spk_delay_buf #(.DEPTH(DEPTH), .DLY_W(DLY_W), .WW(WW), .SUM_W(SUM_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_en     (accept),
      .ins_delay  (lk_delay),
      .ins_weight (lk_weight),
      .age_en     (state_q == SQ_AGE),
      .retire_en  (state_q == SQ_RETIRE),
      .full       (full),
      .mat_sum    (mat_sum)
   );

   spk_neuron_step #(
      .VW(VW), .SUM_W(SUM_W), .LEAK_SHIFT(LEAK_SHIFT),
      .THRESH(THRESH), .V_RESET(V_RESET)
   ) u_step (
      .v_in   (v_q),
      .sum_in (sum_q),
      .v_out  (v_next),
      .fire   (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         pend_q  <= 1'b0;
         req_q   <= 1'b0;
         arm_q   <= 1'b0;
         sum_q   <= '0;
         v_q     <= '0;
      end else begin
         if (state_q != SQ_IDLE && tick) pend_q <= 1'b1;
         unique case (state_q)
            SQ_IDLE: begin
               if (tick || pend_q) begin
                  state_q <= SQ_AGE;
                  pend_q  <= pend_q && tick;
               end
            end
            SQ_AGE: begin
               arm_q   <= req_q;
               req_q   <= 1'b0;
               state_q <= SQ_RETIRE;
            end
            SQ_RETIRE: begin
               sum_q   <= mat_sum;
               state_q <= SQ_INTEG;
            end
            SQ_INTEG: begin
               v_q     <= v_next;
               req_q   <= fire;
               state_q <= SQ_EMIT;
            end
            SQ_EMIT: begin
               if (!arm_q || out_ready) begin
                  arm_q   <= 1'b0;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign out_valid = (state_q == SQ_EMIT) && arm_q;
   assign out_addr  = {NODE_ID, CORE_ID, NRN_ID};
   assign v_state   = v_q;
endmodule

// File: rtl/spk_delay_integrator_chk.sv
module spk_delay_integrator_chk #(
   parameter int          VW      = 16,
   parameter int          THRESH  = 100,
   parameter logic [15:0] NODE_ID = 16'h0A5C,
   parameter logic [3:0]  CORE_ID = 4'h3,
   parameter logic [9:0]  NRN_ID  = 10'h12F
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick,
   input logic                 busy,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [29:0]          out_addr,
   input logic signed [VW-1:0] v_state
);
   AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready); // R8
   AST_READY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !in_ready); // R8
   AST_TICK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick) |=> busy); // R9
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R6
   AST_OUT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_addr == {NODE_ID, CORE_ID, NRN_ID})); // R5
   AST_OUT_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy); // R5
   AST_V_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      v_state < VW'(THRESH)); // R4
endmodule

bind spk_delay_integrator spk_delay_integrator_chk #(
   .VW(VW), .THRESH(THRESH), .NODE_ID(NODE_ID), .CORE_ID(CORE_ID), .NRN_ID(NRN_ID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .busy      (busy),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .v_state   (v_state)
);

// File: tb/tb_spk_delay_integrator.sv
`timescale 1ns/1ps
module tb_spk_delay_integrator;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [29:0]       in_addr = '0;
   logic              tick = 1'b0;
   logic              busy;
   logic              tbl_we = 1'b0;
   logic [9:0]        tbl_addr = '0;
   logic [3:0]        tbl_delay = '0;
   logic signed [7:0] tbl_weight = '0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [29:0]       out_addr;
   logic signed [15:0] v_state;

   int checks = 0;
   int failures = 0;
   int spk_cnt = 0;
   logic [29:0] last_addr = '0;
   int exp_v = 0;
   int exp_pend = 0;
   int exp_spk = 0;
   localparam logic [29:0] SELF_ADDR = {16'h0A5C, 4'h3, 10'h12F};

   spk_delay_integrator dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .tick(tick), .busy(busy), .tbl_we(tbl_we),
      .tbl_addr(tbl_addr), .tbl_delay(tbl_delay), .tbl_weight(tbl_weight),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .v_state(v_state)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         spk_cnt   = spk_cnt + 1;
         last_addr = out_addr;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // independent model of one tick step
   task automatic model_step(input int sum);
      int nv;
      nv = exp_v - (exp_v >>> 3) + sum;
      if (exp_pend != 0) exp_spk++;
      if (nv >= 100) begin
         exp_v = 0;
         exp_pend = 1;
      end else begin
         exp_v = nv;
         exp_pend = 0;
      end
   endtask

   task automatic wr_syn(input int nrn, input int dly, input int wt);
      @(posedge clk); #1;
      tbl_we = 1'b1; tbl_addr = 10'(nrn); tbl_delay = 4'(dly); tbl_weight = 8'(wt);
      @(posedge clk); #1;
      tbl_we = 1'b0;
   endtask

   task automatic send(input int nrn, input logic [19:0] upper);
      logic got;
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_addr  = {upper, 10'(nrn)};
      got = 1'b0;
      while (!got) begin
         @(negedge clk);
         got = in_ready;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic do_tick(input int sum);
      @(posedge clk); #1;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      wait_idle();
      model_step(sum);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R8 reset in_ready", in_ready, 1);
      check("R5 reset out_valid", out_valid, 0);
      check("R9 reset busy", busy, 0);
      check("R3 reset v", v_state, 0);
   endtask

   task automatic t_delay3();
      wr_syn(5, 3, 40);
      send(5, 20'hABCDE);
      do_tick(0);
      check("R1 tick1 v", v_state, exp_v);
      do_tick(0);
      check("R1 tick2 v", v_state, exp_v);
      do_tick(40);
      check("R1 R10 tick3 v", v_state, exp_v);
      do_tick(0);
      check("R3 leak step1", v_state, exp_v);
      do_tick(0);
      check("R3 leak step2", v_state, exp_v);
   endtask

   task automatic t_sum();
      wr_syn(7, 1, 30);
      wr_syn(9, 1, 20);
      send(7, 20'h00001);
      send(9, 20'hFFFFF);
      do_tick(50);
      check("R11 summed v", v_state, exp_v);
   endtask

   task automatic t_fire();
      int c0;
      send(7, 20'h12345);
      send(7, 20'h54321);
      c0 = spk_cnt;
      do_tick(60);
      check("R4 reset v", v_state, exp_v);
      check("R4 fire expected", exp_pend, 1);
      check("R5 no spike same tick", spk_cnt, c0);
      do_tick(0);
      check("R5 spike next tick", spk_cnt, c0 + 1);
      check("R5 spike address", int'(last_addr), int'(SELF_ADDR));
      do_tick(0);
      check("R5 single spike", spk_cnt, exp_spk);
   endtask

   task automatic t_delay0();
      wr_syn(11, 0, 10);
      send(11, 20'h0F0F0);
      do_tick(10);
      check("R2 delay0 v", v_state, exp_v);
   endtask

   task automatic t_full();
      wr_syn(20, 15, 1);
      for (int i = 0; i < 8; i++) send(20, 20'(i));
      @(negedge clk);
      check("R7 full ready low", in_ready, 0);
      @(posedge clk); #1;
      in_valid = 1'b1; in_addr = {20'h0, 10'd20};
      repeat (3) @(negedge clk);
      check("R7 stall ready", in_ready, 0);
      @(posedge clk); #1;
      in_valid = 1'b0;
      for (int i = 0; i < 14; i++) do_tick(0);
      check("R7 still full", in_ready, 0);
      check("R1 before 15", v_state, exp_v);
      do_tick(8);
      check("R7 R1 all retired", v_state, exp_v);
      check("R7 ready again", in_ready, 1);
   endtask

   task automatic t_same_cycle();
      logic got;
      @(posedge clk); #1;
      tick = 1'b1; in_valid = 1'b1; in_addr = {20'h3, 10'd7};
      @(negedge clk);
      check("R8 tick blocks ready", in_ready, 0);
      @(posedge clk); #1;
      tick = 1'b0;
      @(negedge clk);
      check("R8 busy blocks ready", in_ready, 0);
      got = 1'b0;
      while (!got) begin
         @(negedge clk);
         got = in_ready;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      model_step(0);
      wait_idle();
      check("R8 not aged by tick", v_state, exp_v);
      do_tick(30);
      check("R8 applied next tick", v_state, exp_v);
   endtask

   task automatic t_pending();
      int bcyc;
      @(posedge clk); #1;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      @(posedge clk); #1;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      bcyc = 0;
      @(negedge clk);
      while (busy) begin
         bcyc++;
         @(negedge clk);
      end
      model_step(0);
      model_step(0);
      check("R9 two steps", v_state, exp_v);
      check("R9 busy span", (bcyc >= 6) ? 1 : 0, 1);
   endtask

   task automatic t_backpressure();
      wr_syn(21, 1, 127);
      send(21, 20'h77777);
      do_tick(127);
      check("R4 fire armed", exp_pend, 1);
      out_ready = 1'b0;
      @(posedge clk); #1;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      repeat (8) @(negedge clk);
      check("R6 valid held", out_valid, 1);
      check("R6 busy held", busy, 1);
      check("R6 addr held", int'(out_addr), int'(SELF_ADDR));
      @(posedge clk); #1;
      out_ready = 1'b1;
      wait_idle();
      model_step(0);
      check("R6 delivered once", spk_cnt, exp_spk);
      check("R3 v after stall", v_state, exp_v);
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_delay3();
      t_sum();
      t_fire();
      t_delay0();
      t_full();
      t_same_cycle();
      t_pending();
      t_backpressure();
      check("R5 total spikes", spk_cnt, exp_spk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule